// File: doc/BRIEF.md
# Barrel Shifter with Normalization and Block Exponent

This block is a single-cycle shift unit for 16-bit data with a 32-bit result register. Each accepted operation first places the input word in the upper or lower half of a 32-bit field. It then shifts the field by a signed amount and writes the result register. It provides logical and arithmetic shifts, normalization by the word's own exponent, and denormalization, in which a positive count moves the data right. It also derives exponents, which it reports as minus the number of redundant sign bits.

Multiword values are handled in two ways. An OR-merge control combines a new shifted piece with the result already held, so a 32-bit value can be built from two 16-bit halves in two cycles. A normalize applied to a lower-half word reuses the exponent already held in the exponent register. A block-exponent counter holds the smallest redundant-sign-bit count seen since it was last cleared. This supports block floating-point scaling over a run of words.

Top module: `shift_norm_unit`

## Requirements
- R1: After reset, `result` is 0 and `exponent` is 0. The block sign-bit count starts at 15, so a BLKEXP of 0x0000 as the first operation gives exponent -15.
- R2: Operation code 0 (LSH) is a logical shift. The word is placed as {data_in,16'h0} when `hi_sel`=1 and as {16'h0,data_in} when `hi_sel`=0. It is shifted by the 6-bit two's-complement `shamt` (-32..+31): a positive value shifts left and a negative value shifts right. Vacated bits are filled with 0.
- R3: Operation code 1 (ASH) works like LSH, except that a right shift fills the vacated bits with bit 31 of the placed field.
- R4: For operation codes 0 to 3, `or_merge`=1 writes the old result OR the shifted value. `or_merge`=0 writes the shifted value alone.
- R5: Operation code 4 (EXP) sets `exponent` to minus the count of redundant sign bits of `data_in`, as 8-bit two's complement (0 to -15). It leaves `result` unchanged.
- R6: Operation code 2 (NORM) has two forms. With `hi_sel`=1 it shifts {data_in,16'h0} left by the redundant sign bit count n of `data_in` and sets `exponent` to -n. With `hi_sel`=0 it shifts {16'h0,data_in} left by minus the held `exponent` and leaves `exponent` unchanged.
- R7: Operation code 3 (DENORM) is an arithmetic shift in which a positive `shamt` moves the data right and a negative `shamt` moves it left.
- R8: Operation code 5 (BLKEXP) sets the block count to the minimum of the held count and the redundant sign bit count of `data_in`, and sets `exponent` to minus the new count. Operation code 6 (BCLR) sets the count to 15 and `exponent` to -15. Neither operation changes `result`.
- R9: When `in_valid`=0, or when the operation code is 7, `result`, `exponent` and the block count do not change.
- R10: Every operation takes effect on the rising clock edge at which it is presented, and both outputs show the new values right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (see requirements) |
| data_in | input | 16 | Input word |
| shamt | input | 6 | Signed shift amount or exponent, -32..+31 |
| hi_sel | input | 1 | 1 places the word in the upper half, 0 in the lower half |
| or_merge | input | 1 | 1 ORs the shifted value into the held result |
| result | output | 32 | Result register |
| exponent | output | 8 | Exponent register, two's complement |

## Verification
Each operation is presented at a falling edge and is captured on the next rising edge. Both `result` and `exponent` are therefore due one edge later, with no further pipeline delay. The driver pushes one expected item per driven cycle, including idle cycles. After each rising edge the monitor waits 2 ns, pops one item, and compares both outputs. The bench model counts redundant sign bits and shifts bit by bit, and it keeps its own copies of the held exponent and the block count. This lets the checks cover multi-cycle sequences such as the upper-half normalize followed by the lower-half normalize, OR assembly, and block-exponent runs.

// File: rtl/sns_pkg.sv
// Shared widths and operation codes for the shift/normalize unit.
// Assumes a 16-bit input word and a 32-bit result field.
package sns_pkg;
    localparam int DW = 16;               // input word width
    localparam int RW = 2 * DW;           // result field width
    localparam int LG = $clog2(RW);       // bits of a shift count below RW
    localparam int AW = LG + 2;           // signed internal shift amount width
    localparam int CW = $clog2(DW);       // redundant sign bit count width
    localparam int EW = 8;                // exponent width

    typedef enum logic [2:0] {
        OP_LSH    = 3'd0,
        OP_ASH    = 3'd1,
        OP_NORM   = 3'd2,
        OP_DENORM = 3'd3,
        OP_EXP    = 3'd4,
        OP_BLKEXP = 3'd5,
        OP_BCLR   = 3'd6,
        OP_NOP    = 3'd7
    } sns_op_e;
endpackage

// File: rtl/sns_place.sv
// Places a W-bit word in the upper or lower half of a 2W-bit field.
// Assumes the unused half is filled with zeros in both cases.
module sns_place #(
    parameter int W = 16
) (
    input  logic [W-1:0]   word,
    input  logic           upper,
    output logic [2*W-1:0] field
);
    // select the half the word lands in
    always_comb begin
        field = upper ? {word, {W{1'b0}}} : {{W{1'b0}}, word};
    end
endmodule

// File: rtl/sns_rsb.sv
// Counts redundant sign bits: the leading bits after the sign bit that
// equal it. Assumes W >= 2; the count ranges from 0 to W-1.
module sns_rsb #(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] count
);
    // scan down from just below the sign bit until a bit differs
    always_comb begin
        logic run;
        run   = 1'b1;
        count = '0;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (word[i] == word[W-1])) begin
                count = CW'(count + 1'b1);
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sns_barrel.sv
// Logarithmic barrel shifter over an RW-bit field. A signed amount:
// >= 0 shifts left, < 0 shifts right (arithmetic when arith is set).
// Assumes the magnitude does not exceed RW; a magnitude of RW clears or sign-fills.
module sns_barrel #(
    parameter int RW = 32,
    parameter int LG = $clog2(RW),
    parameter int AW = LG + 2
) (
    input  logic [RW-1:0] val,
    input  logic [AW-1:0] amt,
    input  logic          arith,
    output logic [RW-1:0] out
);
    localparam int ST = LG + 1;

    logic [AW-1:0] neg_amt;
    logic [ST-1:0] mag;
    logic [RW-1:0] lft [0:ST];
    logic [RW-1:0] rgt [0:ST];

    // magnitude of the signed shift amount
    always_comb begin
        neg_amt = AW'(~amt + 1'b1);
        mag     = amt[AW-1] ? neg_amt[ST-1:0] : amt[ST-1:0];
    end

    assign lft[0] = val;
    assign rgt[0] = val;

    for (genvar k = 0; k < ST; k++) begin : g_stage
        localparam int D = 1 << k;
        if (D >= RW) begin : g_full
            assign lft[k+1] = mag[k] ? '0 : lft[k];
            assign rgt[k+1] = mag[k] ? {RW{arith & rgt[k][RW-1]}} : rgt[k];
        end else begin : g_part
            assign lft[k+1] = mag[k] ? {lft[k][RW-1-D:0], {D{1'b0}}} : lft[k];
            assign rgt[k+1] = mag[k] ? {{D{arith & rgt[k][RW-1]}}, rgt[k][RW-1:D]}
                                     : rgt[k];
        end
    end

    // pick the direction
    always_comb begin
        out = amt[AW-1] ? rgt[ST] : lft[ST];
    end
endmodule

// File: rtl/shift_norm_unit.sv
// Single-cycle shift/normalize unit: places a 16-bit word in a 32-bit
// field, shifts it, optionally ORs into the held result, derives
// exponents and tracks a block exponent. Assumes one operation per
// cycle qualified by in_valid; synchronous active-low reset.
module shift_norm_unit
    import sns_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [DW-1:0] data_in,
    input  logic [5:0]    shamt,
    input  logic          hi_sel,
    input  logic          or_merge,
    output logic [RW-1:0] result,
    output logic [EW-1:0] exponent
);
    logic [RW-1:0] placed;
    logic [RW-1:0] shifted;
    logic [RW-1:0] merged;
    logic [CW-1:0] rsb;
    logic [CW-1:0] blk_cnt;
    logic [CW-1:0] blk_next;
    logic [AW-1:0] amt;
    logic [AW-1:0] sh_ext;
    logic [EW-1:0] exp_neg;
    logic          arith;
    sns_op_e       opc;

    assign opc = sns_op_e'(op);

    sns_place #(.W(DW)) u_place (
        .word  (data_in),
        .upper (hi_sel),
        .field (placed)
    );

    sns_rsb #(.W(DW), .CW(CW)) u_rsb (
        .word  (data_in),
        .count (rsb)
    );

    sns_barrel #(.RW(RW), .LG(LG), .AW(AW)) u_barrel (
        .val   (placed),
        .amt   (amt),
        .arith (arith),
        .out   (shifted)
    );

    // choose the signed shift amount and fill type for the operation
    always_comb begin
        sh_ext  = AW'($signed(shamt));
        exp_neg = EW'(~exponent + 1'b1);
        arith   = (opc == OP_ASH) || (opc == OP_DENORM);
        case (opc)
            OP_DENORM: amt = AW'(~sh_ext + 1'b1);
            OP_NORM:   amt = hi_sel ? AW'(rsb) : exp_neg[AW-1:0];
            default:   amt = sh_ext;
        endcase
    end

    // merge with the held result and fold the block count
    always_comb begin
        merged   = or_merge ? (result | shifted) : shifted;
        blk_next = (rsb < blk_cnt) ? rsb : blk_cnt;
    end

    // update result, exponent and block count on accepted operations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            exponent <= '0;
            blk_cnt  <= CW'(DW - 1);
        end else if (in_valid) begin
            case (opc)
                OP_LSH, OP_ASH, OP_DENORM: result <= merged;
                OP_NORM: begin
                    result <= merged;
                    if (hi_sel) exponent <= EW'(~EW'(rsb) + 1'b1);
                end
                OP_EXP:    exponent <= EW'(~EW'(rsb) + 1'b1);
                OP_BLKEXP: begin
                    blk_cnt  <= blk_next;
                    exponent <= EW'(~EW'(blk_next) + 1'b1);
                end
                OP_BCLR: begin
                    blk_cnt  <= CW'(DW - 1);
                    exponent <= EW'(~EW'(DW - 1) + 1'b1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sns_chk.sv
// Assertion checker for shift_norm_unit, bound to every instance.
// Assumes the port names of the unit.
module sns_chk
    import sns_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    op,
    input logic [DW-1:0] data_in,
    input logic          hi_sel,
    input logic          or_merge,
    input logic [RW-1:0] result,
    input logic [EW-1:0] exponent
);
    // R9: idle cycles keep both outputs
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(exponent)));

    // R5: a derived exponent lies in 0..-15
    a_r5_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4) |=>
            ($signed(exponent) <= 0 && $signed(exponent) >= -15));

    // R8: clearing the block count reports -15
    a_r8_bclr_value: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd6) |=> (exponent == 8'hF1));

    // R8/R5: exponent-only operations keep the result
    a_r8_result_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2]) |=> $stable(result));

    // R6: an upper-half normalize of a nonzero word leaves bits 31 and 30 unequal
    a_r6_norm_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2 && hi_sel && !or_merge && data_in != '0)
            |=> (result[RW-1] != result[RW-2]));

    // R4: an OR merge never clears a held bit
    a_r4_merge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && or_merge && !op[2]) |=>
            ((result & $past(result)) == $past(result)));
endmodule

bind shift_norm_unit sns_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op       (op),
    .data_in  (data_in),
    .hi_sel   (hi_sel),
    .or_merge (or_merge),
    .result   (result),
    .exponent (exponent)
);

// File: tb/sim_shift_norm_unit.sv
`timescale 1ns/1ps
module sim_shift_norm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] data_in = 16'h0;
    logic [5:0]  shamt = 6'd0;
    logic        hi_sel = 1'b0;
    logic        or_merge = 1'b0;
    logic [31:0] result;
    logic [7:0]  exponent;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] r;
        int          e;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // bench model state
    logic [31:0] m_res = 32'h0;
    int          m_exp = 0;
    int          m_cnt = 15;

    always #4 clk = ~clk;

    shift_norm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .data_in(data_in), .shamt(shamt), .hi_sel(hi_sel),
        .or_merge(or_merge), .result(result), .exponent(exponent)
    );

    function automatic int f_rsb(logic [15:0] d);
        int n = 0;
        for (int i = 14; i >= 0; i--)
            if (d[i] == d[15] && n == 14 - i) n++;
        return n;
    endfunction

    function automatic logic [31:0] f_sh(logic [31:0] v, int a, bit ar);
        logic [31:0] r = v;
        if (a >= 0) begin
            for (int i = 0; i < a; i++) r = {r[30:0], 1'b0};
        end else begin
            for (int i = 0; i < -a; i++) r = {ar ? r[31] : 1'b0, r[31:1]};
        end
        return r;
    endfunction

    // driver: present one cycle and push what is due after the next edge
    task automatic drive(input bit v, input int o, input logic [15:0] d,
                         input int sa, input bit hi, input bit orm,
                         input string tag);
        logic [31:0] p, s;
        int n;
        @(negedge clk);
        in_valid = v; op = 3'(o); data_in = d; shamt = 6'(sa);
        hi_sel = hi; or_merge = orm;
        p = hi ? {d, 16'h0} : {16'h0, d};
        n = f_rsb(d);
        if (v) begin
            s = 32'h0;
            case (o)
                0: s = f_sh(p, sa, 1'b0);
                1: s = f_sh(p, sa, 1'b1);
                2: s = hi ? f_sh(p, n, 1'b0) : f_sh(p, -m_exp, 1'b0);
                3: s = f_sh(p, -sa, 1'b1);
                default: ;
            endcase
            if (o <= 3) m_res = orm ? (m_res | s) : s;
            if (o == 2 && hi) m_exp = -n;
            if (o == 4) m_exp = -n;
            if (o == 5) begin
                if (n < m_cnt) m_cnt = n;
                m_exp = -m_cnt;
            end
            if (o == 6) begin m_cnt = 15; m_exp = -15; end
        end
        sb.push_back('{m_res, m_exp, tag});
    endtask

    // monitor: compare 2 ns after each rising edge that owes a result
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            #2;
            checks++;
            if (result !== x.r || $signed(exponent) != x.e) begin
                errors++;
                $display("FAIL %s: result=%h exponent=%0d expected result=%h exponent=%0d",
                         x.tag, result, $signed(exponent), x.r, x.e);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || exponent !== 8'h0) begin
            errors++;
            $display("FAIL R1 reset: result=%h exponent=%h expected 0 0", result, exponent);
        end
        drive(1, 5, 16'h0000, 0, 1, 0, "R1 block count starts at 15");
        drive(1, 0, 16'hA5C3, 4, 1, 0, "R2 lsh hi left 4");
        drive(1, 0, 16'hA5C3, -3, 1, 0, "R2 lsh hi right 3");
        drive(1, 0, 16'h8001, 31, 0, 0, "R2 lsh lo left 31");
        drive(1, 0, 16'hFFFF, -32, 1, 0, "R2 lsh right 32");
        drive(1, 1, 16'h8421, -5, 1, 0, "R3 ash hi right 5");
        drive(1, 1, 16'h8421, -32, 1, 0, "R3 ash right 32");
        drive(1, 1, 16'h8421, -4, 0, 0, "R3 ash lo right 4");
        drive(1, 0, 16'h1234, 0, 1, 0, "R4 merge step hi");
        drive(1, 0, 16'h5678, 0, 0, 1, "R4 merge step lo");
        drive(1, 1, 16'h00F0, 8, 0, 1, "R4 merge ash");
        drive(1, 4, 16'h0003, 0, 1, 0, "R5 exp small positive");
        drive(1, 4, 16'hFFFE, 0, 1, 0, "R5 exp small negative");
        drive(1, 4, 16'h4000, 0, 1, 0, "R5 exp zero count");
        drive(1, 2, 16'h0012, 0, 1, 0, "R6 norm hi");
        drive(1, 2, 16'hC3A0, 0, 0, 1, "R6 norm lo with held exponent");
        drive(1, 2, 16'hFFFF, 0, 1, 0, "R6 norm minus one");
        drive(1, 3, 16'h9000, 6, 1, 0, "R7 denorm right 6");
        drive(1, 3, 16'h0009, -3, 0, 0, "R7 denorm left 3");
        drive(1, 3, 16'h7000, 31, 1, 0, "R7 denorm right 31");
        drive(1, 6, 16'h0000, 0, 1, 0, "R8 bclr");
        drive(1, 5, 16'h0100, 0, 1, 0, "R8 blkexp first");
        drive(1, 5, 16'h3000, 0, 1, 0, "R8 blkexp smaller");
        drive(1, 5, 16'hFF00, 0, 1, 0, "R8 blkexp larger kept");
        drive(0, 0, 16'hFFFF, 5, 1, 0, "R9 idle lsh");
        drive(0, 6, 16'hFFFF, 0, 1, 1, "R9 idle bclr");
        drive(1, 7, 16'hFFFF, 9, 1, 1, "R9 op 7 no effect");
        drive(1, 5, 16'h7FFF, 0, 1, 0, "R9 block count held");
        drive(1, 0, 16'h0001, 1, 0, 0, "R10 back to back a");
        drive(1, 1, 16'h8000, -1, 1, 1, "R10 back to back b");
        drive(0, 0, 16'h0, 0, 0, 0, "R10 drain");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule